// File: doc/BRIEF.md
# Banked BCD Calendar Clock

This block keeps wall-clock time and date as fifteen separate 4-bit decimal digits. The digits are seconds, minutes, hours, day of week, day of month, month and a four-digit year. A prescaler divides the system clock down to one tick per second. Each tick opens a short update window, and the window advances the time by one second. The advance carries through minutes, hours, the day of week, the month length (with the full leap-year rule), the month and the year. The year wraps from 9999 to 0000.

A host reaches the digits through a small parallel port with a 4-bit address, 4-bit data, a read strobe and a write strobe. Reads are combinational, and `rd_data` reads zero when `rd_en` is low. Address 0xF is a control nibble that is visible in every bank. Through it the host picks one of four banks, freezes counting while it loads a new time, and polls a busy flag. The host should read the time only while busy reads zero. Bank 2 holds a 2-bit timer control register that is kept only as storage.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the control nibble reads 0 and the digits hold 2000-01-01, day of week 0, 00:00:00.
- R2: The control nibble at address 0xF reads busy in bit 0, the stop bit in bit 1 and the bank number in bits 3:2. A write sets stop and the bank, and the value written to bit 0 is ignored.
- R3: In bank 0, addresses 0x0 to 0xE map to these digits: seconds ones and tens, minutes ones and tens, hours ones and tens, day of week, day ones and tens, month ones and tens, then year ones, tens, hundreds and thousands. A write takes effect on the strobe and reads back unchanged.
- R4: While stop is set the digits do not advance, and the prescaler is held cleared.
- R5: Each second, busy is high for exactly BUSY_CYCLES clock cycles. The digits change only at the end of that window, so they are stable whenever busy reads 0, apart from host writes.
- R6: Seconds and minutes count 00 to 59 and hours count 00 to 23, each with a BCD carry to the next field.
- R7: The day of week counts 0 to 6, advances when the day rolls over, and wraps from 6 to 0.
- R8: Day 30 rolls over in months 4, 6, 9 and 11, and day 31 in the other months. Month 12 wraps to month 1 and increments the four-digit BCD year, and 9999 wraps to 0000.
- R9: February has 29 days when the year is divisible by 4, except for a century year that is not divisible by 400 (2000 is a leap year, 2100 is not).
- R10: In bank 2, address 0xE stores bits 1:0 of a timer control register, and bits 3:2 read as 0.
- R11: In banks 1 and 3, and at bank 2 addresses other than 0xE, reads return 0 and writes change nothing. `rd_data` is 0 while `rd_en` is low.
- R12: While running, the update window starts once every DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_data | input | 4 | Write data nibble |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; gates rd_data |
| rd_data | output | 4 | Read data nibble, combinational |

## Verification
A wrong carry or month-length decision shows up only on the one tick that crosses its boundary. The bench therefore loads a time just before each rollover, releases stop, and compares all fifteen digits as soon as busy drops, one second later. A stuck prescaler or busy counter shows up as a wrong busy width or a wrong tick spacing within a single period. Bank decode errors show up as nonzero reads or as corrupted digits immediately after a stray write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NUM_DIGITS = 15;
    localparam int D_S1 = 0, D_S10 = 1, D_MI1 = 2, D_MI10 = 3, D_H1 = 4, D_H10 = 5;
    localparam int D_DOW = 6, D_D1 = 7, D_D10 = 8, D_MO1 = 9, D_MO10 = 10;
    localparam int D_Y1 = 11, D_Y10 = 12, D_Y100 = 13, D_Y1000 = 14;
    localparam logic [3:0] CTRL_ADDR  = 4'hF;
    localparam logic [3:0] TIMER_ADDR = 4'hE;

    typedef logic [NUM_DIGITS-1:0][3:0] digits_t;

    typedef enum logic [1:0] {
        BANK_TIME  = 2'd0,
        BANK_ONE   = 2'd1,
        BANK_TIMER = 2'd2,
        BANK_THREE = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e bank;
        logic  stop;
    } ctrl_t;

    localparam digits_t RESET_TIME = 60'h2000_01_01_0_00_00_00;

    function automatic logic leap_year(input digits_t d);
        int lo, hi;
        lo = int'(d[D_Y10]) * 10 + int'(d[D_Y1]);
        hi = int'(d[D_Y1000]) * 10 + int'(d[D_Y100]);
        if (lo == 0) return (hi % 4) == 0;
        return (lo % 4) == 0;
    endfunction

    function automatic int month_len(input int month, input logic leap);
        case (month)
            2:             return leap ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    // Advance one second with BCD carry through the whole calendar.
    function automatic digits_t advance(input digits_t t);
        digits_t d;
        int day, mon;
        d = t;
        if (d[D_S1] < 4'd9) begin d[D_S1] = d[D_S1] + 4'd1; return d; end
        d[D_S1] = 4'd0;
        if (d[D_S10] < 4'd5) begin d[D_S10] = d[D_S10] + 4'd1; return d; end
        d[D_S10] = 4'd0;
        if (d[D_MI1] < 4'd9) begin d[D_MI1] = d[D_MI1] + 4'd1; return d; end
        d[D_MI1] = 4'd0;
        if (d[D_MI10] < 4'd5) begin d[D_MI10] = d[D_MI10] + 4'd1; return d; end
        d[D_MI10] = 4'd0;
        if (d[D_H10] >= 4'd2 && d[D_H1] >= 4'd3) begin
            d[D_H10] = 4'd0;
            d[D_H1]  = 4'd0;
        end else if (d[D_H1] >= 4'd9) begin
            d[D_H1]  = 4'd0;
            d[D_H10] = d[D_H10] + 4'd1;
            return d;
        end else begin
            d[D_H1] = d[D_H1] + 4'd1;
            return d;
        end
        d[D_DOW] = (d[D_DOW] >= 4'd6) ? 4'd0 : d[D_DOW] + 4'd1;
        day = int'(d[D_D10]) * 10 + int'(d[D_D1]);
        mon = int'(d[D_MO10]) * 10 + int'(d[D_MO1]);
        if (day < month_len(mon, leap_year(d))) begin
            if (d[D_D1] >= 4'd9) begin d[D_D1] = 4'd0; d[D_D10] = d[D_D10] + 4'd1; end
            else d[D_D1] = d[D_D1] + 4'd1;
            return d;
        end
        d[D_D10] = 4'd0;
        d[D_D1]  = 4'd1;
        if (mon < 12) begin
            if (d[D_MO1] >= 4'd9) begin d[D_MO1] = 4'd0; d[D_MO10] = d[D_MO10] + 4'd1; end
            else d[D_MO1] = d[D_MO1] + 4'd1;
            return d;
        end
        d[D_MO10] = 4'd0;
        d[D_MO1]  = 4'd1;
        for (int i = D_Y1; i <= D_Y1000; i++) begin
            if (d[i] < 4'd9) begin d[i] = d[i] + 4'd1; return d; end
            d[i] = 4'd0;
        end
        return d;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic stop,
    output logic busy,
    output logic advance_en
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0] LOAD = BW'(BUSY_CYCLES);

    logic [BW-1:0] left_q;

    assign busy       = (left_q != '0);
    assign advance_en = (left_q == BW'(1)) && !stop;

    always_ff @(posedge clk) begin
        if (rst)       left_q <= '0;
        else if (tick) left_q <= LOAD;
        else if (busy) left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance_en,
    input  logic       wr_dig,
    input  logic [3:0] wr_idx,
    input  logic [3:0] wr_val,
    output digits_t    digits
);
    digits_t cur_q, nxt;

    always_comb begin
        nxt = advance_en ? advance(cur_q) : cur_q;
        if (wr_dig) nxt[wr_idx] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RESET_TIME;
        else     cur_q <= nxt;
    end

    assign digits = cur_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV         = 50_000_000,
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] addr,
    input  logic [3:0] wr_data,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [3:0] rd_data
);
    ctrl_t      ctrl_q;
    logic [1:0] timer_q;
    logic       tick, busy, advance_en, wr_dig;
    digits_t    digits;

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst(rst), .run(!ctrl_q.stop), .tick(tick)
    );

    rtc_update_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .stop(ctrl_q.stop),
        .busy(busy), .advance_en(advance_en)
    );

    assign wr_dig = wr_en && (ctrl_q.bank == BANK_TIME) && (addr != CTRL_ADDR);

    rtc_calendar u_cal (
        .clk(clk), .rst(rst), .advance_en(advance_en), .wr_dig(wr_dig),
        .wr_idx(addr), .wr_val(wr_data), .digits(digits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{bank: BANK_TIME, stop: 1'b0};
            timer_q <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_ADDR)
                ctrl_q <= '{bank: bank_e'(wr_data[3:2]), stop: wr_data[1]};
            else if (ctrl_q.bank == BANK_TIMER && addr == TIMER_ADDR)
                timer_q <= wr_data[1:0];
        end
    end

    always_comb begin
        rd_data = 4'h0;
        if (rd_en) begin
            if (addr == CTRL_ADDR)
                rd_data = {ctrl_q.bank, ctrl_q.stop, busy};
            else if (ctrl_q.bank == BANK_TIME)
                rd_data = digits[addr];
            else if (ctrl_q.bank == BANK_TIMER && addr == TIMER_ADDR)
                rd_data = {2'b00, timer_q};
        end
    end
endmodule

// File: rtl/bcd_rtc_core_checker.sv
module bcd_rtc_core_checker
    import rtc_pkg::*;
#(
    parameter int DIV         = 50_000_000,
    parameter int BUSY_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [3:0] rd_data,
    input logic       busy,
    input logic       tick,
    input logic       stop,
    input digits_t    digits
);
    logic        host_dig_wr;
    logic [31:0] tick_gap, busy_len;

    assign host_dig_wr = wr_en && (addr != CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst || stop || tick) tick_gap <= '0;
        else                     tick_gap <= tick_gap + 1;
        if (rst || !busy) busy_len <= '0;
        else              busy_len <= busy_len + 1;
    end

    assert_busy_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CTRL_ADDR) |-> (rd_data[0] == busy));

    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (stop && !host_dig_wr) |=> $stable(digits));

    assert_busy_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == 32'(BUSY_CYCLES)));

    assert_quiet_outside_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !host_dig_wr) |=> $stable(digits));

    assert_dow_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!host_dig_wr && digits[D_DOW] != 4'd6 && digits[D_DOW] < 4'd7)
        |=> (digits[D_DOW] == $past(digits[D_DOW]) ||
             digits[D_DOW] == $past(digits[D_DOW]) + 4'd1));

    assert_tick_period_R12: assert property (@(posedge clk) disable iff (rst)
        tick |-> (tick_gap == 32'(DIV - 1)));
endmodule

bind bcd_rtc_core bcd_rtc_core_checker #(.DIV(DIV), .BUSY_CYCLES(BUSY_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .busy(busy), .tick(tick), .stop(ctrl_q.stop),
    .digits(digits)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int DIV  = 12;
    localparam int BUSY = 3;
    localparam int NV   = 14;

    // Digit order in each literal: YYYY_MM_DD_W_HH_MM_SS (address 0xE down to 0x0)
    localparam logic [59:0] VIN [NV] = '{
        60'h2023_03_14_2_10_20_30,   // R6 seconds
        60'h2023_03_14_2_10_20_59,   // R6 seconds to minutes
        60'h2023_03_14_2_10_59_59,   // R6 minutes to hours
        60'h2023_03_14_2_19_59_59,   // R6 hours ones carry
        60'h2023_03_14_6_23_59_59,   // R7 day of week wrap
        60'h2023_04_30_1_23_59_59,   // R8 30-day month
        60'h2024_02_28_3_23_59_59,   // R9 leap Feb 28
        60'h2024_02_29_4_23_59_59,   // R9 leap Feb 29
        60'h2100_02_28_0_23_59_59,   // R9 century not leap
        60'h2000_02_28_1_23_59_59,   // R9 400-year leap
        60'h1999_12_31_5_23_59_59,   // R8 year carry
        60'h9999_12_31_5_23_59_59,   // R8 year wrap
        60'h2023_02_28_2_23_59_59,   // R9 plain year
        60'h2023_01_31_2_23_59_59    // R8 31-day month
    };
    localparam logic [59:0] VEXP [NV] = '{
        60'h2023_03_14_2_10_20_31,
        60'h2023_03_14_2_10_21_00,
        60'h2023_03_14_2_11_00_00,
        60'h2023_03_14_2_20_00_00,
        60'h2023_03_15_0_00_00_00,
        60'h2023_05_01_2_00_00_00,
        60'h2024_02_29_4_00_00_00,
        60'h2024_03_01_5_00_00_00,
        60'h2100_03_01_1_00_00_00,
        60'h2000_02_29_2_00_00_00,
        60'h2000_01_01_6_00_00_00,
        60'h0000_01_01_6_00_00_00,
        60'h2023_03_01_3_00_00_00,
        60'h2023_02_01_3_00_00_00
    };
    localparam int VREQ [NV] = '{6, 6, 6, 6, 7, 8, 9, 9, 9, 9, 8, 8, 9, 8};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0, wr_data = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] rd_data;
    int         errors = 0, checks = 0;

    always #10 clk = ~clk;

    bcd_rtc_core #(.DIV(DIV), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic read_all(output logic [59:0] t);
        logic [3:0] v;
        for (int i = 0; i < 15; i++) begin
            rd(4'(i), v);
            t[i*4 +: 4] = v;
        end
    endtask

    task automatic load_time(input logic [59:0] t);
        wr(4'hF, 4'b0010);
        for (int i = 0; i < 15; i++) wr(4'(i), t[i*4 +: 4]);
        wr(4'hF, 4'b0000);
    endtask

    task automatic wait_busy(input logic level);
        logic [3:0] v;
        for (int n = 0; n < 4 * DIV; n++) begin
            rd(4'hF, v);
            if (v[0] == level) return;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [59:0] t;
        logic [3:0]  v;
        int          n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'hF, v);
        check("R1 ctrl", 64'(v), 64'h0);
        read_all(t);
        check("R1 digits", 64'(t), 64'h2000_01_01_0_00_00_00);

        // Vector table: load one second before a boundary, then compare
        for (int k = 0; k < NV; k++) begin
            load_time(VIN[k]);
            wait_busy(1'b1);
            wait_busy(1'b0);
            read_all(t);
            check($sformatf("R%0d vector %0d", VREQ[k], k), 64'(t), 64'(VEXP[k]));
        end

        // R5 busy width and digits stable during the window; R12 spacing
        load_time(60'h2023_03_14_2_10_20_30);
        wait_busy(1'b1);
        rd(4'h0, v);
        check("R5 digit held while busy", 64'(v), 64'h0);
        n = 1;
        forever begin
            @(negedge clk);
            rd(4'hF, v);
            if (!v[0]) break;
            n++;
        end
        check("R5 busy cycles", 64'(n), 64'(BUSY));
        rd(4'h0, v);
        check("R5 digit after busy", 64'(v), 64'h1);
        n = BUSY;
        forever begin
            @(negedge clk);
            n++;
            rd(4'hF, v);
            if (v[0]) break;
        end
        check("R12 tick spacing", 64'(n), 64'(DIV));

        // R2 control nibble, busy bit write ignored
        wr(4'hF, 4'b1011);
        repeat (BUSY + 2) @(negedge clk);
        rd(4'hF, v);
        check("R2 ctrl readback", 64'(v), 64'b1010);

        // R10 timer control storage in bank 2
        wr(4'hE, 4'hF);
        rd(4'hE, v);
        check("R10 timer ctrl", 64'(v), 64'h3);
        rd(4'h0, v);
        check("R11 bank2 other addr", 64'(v), 64'h0);

        // R3 digit write and readback in bank 0, stopped
        wr(4'hF, 4'b0010);
        for (int i = 0; i < 15; i++) wr(4'(i), 4'(i) ^ 4'h5);
        read_all(t);
        for (int i = 0; i < 15; i++)
            check($sformatf("R3 addr %0d", i), 64'(t[i*4 +: 4]), 64'(4'(i) ^ 4'h5));

        // R4 stopped: nothing advances over several periods
        repeat (3 * DIV) @(negedge clk);
        read_all(t);
        check("R4 stop hold", 64'(t[7:0]), 64'h05 ^ 64'h40);

        // R11 banks 1 and 3 read zero and ignore writes
        wr(4'hF, 4'b0110);
        wr(4'h0, 4'h9);
        rd(4'h0, v);
        check("R11 bank1 read", 64'(v), 64'h0);
        wr(4'hF, 4'b1110);
        wr(4'hE, 4'h7);
        rd(4'hE, v);
        check("R11 bank3 read", 64'(v), 64'h0);
        wr(4'hF, 4'b1010);
        rd(4'hE, v);
        check("R11 bank3 write ignored", 64'(v), 64'h3);
        wr(4'hF, 4'b0010);
        rd(4'h0, v);
        check("R11 bank1 write ignored", 64'(v), 64'h5);
        addr = 4'h0; rd_en = 1'b0;
        #1 check("R11 rd_en low", 64'(rd_data), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule